// File: doc/BRIEF.md
# DMA Channel Register Interface

This block is the software-facing register file of a four-channel DMA controller in the classic PC arrangement. A host reaches it through an 8-bit register port with a 4-bit offset and separate write and read strobes. For every channel it keeps a service-mode setting, a mask bit, a software request bit, a 16-bit start address and a 16-bit transfer count. It also holds one command byte that is shared by all channels.

The 16-bit values go through the 8-bit port as pairs of byte accesses. One shared byte-order flag decides whether an access reaches the low half or the high half. Software resets that flag with a dedicated command before it starts a pair. Mask and request bits change one channel per write, through set/clear commands that carry the channel number in the data byte.

The block merges the hardware request lines with the software requests and the masks into one effective request per channel. It exports every channel's configuration to the transfer engine that sits beside it.

Top module: `dma_regif`

## Requirements
- R1: After reset all four mask bits read 1, all software requests are 0, the byte-order flag is clear, and the command byte, modes, addresses and counts are 0.
- R2: A write to offset 0x9 sets (data bit 2 = 1) or clears (data bit 2 = 0) the software request of the channel in data bits 1:0. Data bits 7:3 and the other channels' requests are not affected.
- R3: A write to offset 0xA sets (bit 2 = 1) or clears (bit 2 = 0) the mask of the channel in data bits 1:0. The other channels' masks stay unchanged.
- R4: A write to offset 0xB loads the mode of the channel in data bits 1:0. Bits 3:2 are the transfer kind (00 verify, 01 write, 10 read, 11 illegal). Bit 4 enables auto-reload. Bit 5 selects address decrement (1) or increment (0). Bits 7:6 are the service mode (00 demand, 01 single, 10 block, 11 cascade). The fields are exported per channel in the same encodings.
- R5: A write of any data to offset 0xC clears the byte-order flag.
- R6: Offset 2n is channel n's address and offset 2n+1 its count. A read or write there reaches the low byte while the flag is clear and the high byte while it is set, and each such access toggles the flag.
- R7: A write to offset 0x8 loads the command byte. Its bit 0 is exported as the memory-to-memory enable.
- R8: Each channel's effective request is (hardware request OR software request) AND NOT mask.
- R9: A channel's illegal flag is 1 exactly while its stored transfer kind is 11, its service mode is not cascade, and the memory-to-memory enable is 0.
- R10: Writes to offsets 0xD-0xF change nothing. Reads of offsets 0x8-0xF return 0 and leave the byte-order flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| dreq_hw | input | 4 | Hardware request per channel |
| eff_req_o | output | 4 | Effective request per channel |
| mask_o | output | 4 | Mask bit per channel |
| swreq_o | output | 4 | Software request per channel |
| illegal_o | output | 4 | Illegal transfer kind loaded, per channel |
| auto_init_o | output | 4 | Auto-reload enable per channel |
| addr_dec_o | output | 4 | Address decrement per channel |
| xfer_type_o | output | 8 | Transfer kind, 2 bits per channel |
| svc_mode_o | output | 8 | Service mode, 2 bits per channel |
| base_addr_o | output | 64 | Start address, 16 bits per channel |
| word_cnt_o | output | 64 | Transfer count, 16 bits per channel |
| cmd_o | output | 8 | Command byte |
| mem2mem_o | output | 1 | Memory-to-memory enable |

## Verification
The assertions watch four things on every cycle: a mask or request command changes at most one channel's bit; no effective request appears on a masked channel; the byte-order flag clears after the clear command and flips after every wide access; and an illegal flag is never raised unless the kind stored is 11. The bench's scenarios are needed for the rest. These are the exact byte placement in the 16-bit registers, the shared flag carried from an address access into a count access, the read-back values, the field encodings of the mode write, the masking of the illegal flag by cascade and memory-to-memory, and the return to reset values in the middle of a run.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  localparam logic [3:0] OFS_CMD   = 4'h8;
  localparam logic [3:0] OFS_REQ   = 4'h9;
  localparam logic [3:0] OFS_MASK  = 4'hA;
  localparam logic [3:0] OFS_MODE  = 4'hB;
  localparam logic [3:0] OFS_CLRFF = 4'hC;

  typedef enum logic [1:0] {XF_VERIFY, XF_WRITE, XF_READ, XF_ILLEGAL} xfer_e;
  typedef enum logic [1:0] {SV_DEMAND, SV_SINGLE, SV_BLOCK, SV_CASCADE} svc_e;

  // field order follows data bits 7:2 of the mode write
  typedef struct packed {
    svc_e  svc;
    logic  dec;
    logic  autoinit;
    xfer_e xfer;
  } mode_t;

  function automatic mode_t mode_from_byte(input logic [BYTE_W-1:0] d);
    return mode_t'(d[7:2]);
  endfunction

  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] w,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic hi);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic logic mode_illegal(input mode_t m, input logic m2m);
    return (m.xfer == XF_ILLEGAL) && (m.svc != SV_CASCADE) && !m2m;
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic toggle,
  output logic ptr_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_hi <= 1'b0;
    else if (clr)    ptr_hi <= 1'b0;
    else if (toggle) ptr_hi <= ~ptr_hi;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regif_pkg::*;
#(
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned SELW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr_req,
  input  logic              ev_wr_mask,
  input  logic              ev_wr_mode,
  input  logic [SELW-1:0]   cmd_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ev_wide_wr,
  input  logic [SELW-1:0]   wide_ch,
  input  logic              wide_is_cnt,
  input  logic              ptr_hi,
  output logic              mask_q,
  output logic              swreq_q,
  output mode_t             mode_q,
  output logic [WORD_W-1:0] base_q,
  output logic [WORD_W-1:0] cnt_q
);
  localparam logic [SELW-1:0] MY_ID = SELW'(CH_IDX);

  logic cmd_hit, wide_hit;
  assign cmd_hit  = (cmd_sel == MY_ID);
  assign wide_hit = ev_wide_wr && (wide_ch == MY_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      swreq_q <= 1'b0;
      mode_q  <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (ev_wr_req && cmd_hit)  swreq_q <= wdata[2];
      if (ev_wr_mask && cmd_hit) mask_q  <= wdata[2];
      if (ev_wr_mode && cmd_hit) mode_q  <= mode_from_byte(wdata);
      if (wide_hit && !wide_is_cnt) base_q <= merge_word(base_q, wdata, ptr_hi);
      if (wide_hit && wide_is_cnt)  cnt_q  <= merge_word(cnt_q, wdata, ptr_hi);
    end
  end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] swreq,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] eff
);
  for (genvar i = 0; i < NCH; i++) begin : g_gate
    assign eff[i] = (dreq[i] | swreq[i]) & ~mask[i];
  end
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [BYTE_W-1:0]     reg_wdata,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  output logic [BYTE_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]        dreq_hw,
  output logic [NCH-1:0]        eff_req_o,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH-1:0]        swreq_o,
  output logic [NCH-1:0]        illegal_o,
  output logic [NCH-1:0]        auto_init_o,
  output logic [NCH-1:0]        addr_dec_o,
  output logic [2*NCH-1:0]      xfer_type_o,
  output logic [2*NCH-1:0]      svc_mode_o,
  output logic [WORD_W*NCH-1:0] base_addr_o,
  output logic [WORD_W*NCH-1:0] word_cnt_o,
  output logic [BYTE_W-1:0]     cmd_o,
  output logic                  mem2mem_o
);
  localparam int unsigned SELW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [ADDR_W:0] WIDE_LIM = (ADDR_W+1)'(2 * NCH);

  // named internal events
  logic ev_wr_req, ev_wr_mask, ev_wr_mode, ev_wr_cmd, ev_clr_ptr;
  logic wide_hit, ev_wide_wr, ev_wide_rd, ev_wide_acc;
  logic byte_ptr;
  logic [SELW-1:0] cmd_sel, wide_ch;
  logic wide_is_cnt;

  assign ev_wr_req   = reg_wr && (reg_addr == OFS_REQ);
  assign ev_wr_mask  = reg_wr && (reg_addr == OFS_MASK);
  assign ev_wr_mode  = reg_wr && (reg_addr == OFS_MODE);
  assign ev_wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
  assign ev_clr_ptr  = reg_wr && (reg_addr == OFS_CLRFF);
  assign wide_hit    = ({1'b0, reg_addr} < WIDE_LIM);
  assign ev_wide_wr  = reg_wr && wide_hit;
  assign ev_wide_rd  = reg_rd && !reg_wr && wide_hit;
  assign ev_wide_acc = ev_wide_wr || ev_wide_rd;
  assign cmd_sel     = reg_wdata[SELW-1:0];
  assign wide_ch     = reg_addr[SELW:1];
  assign wide_is_cnt = reg_addr[0];

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ev_clr_ptr),
    .toggle (ev_wide_acc),
    .ptr_hi (byte_ptr)
  );

  logic [BYTE_W-1:0] cmd_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         cmd_q <= '0;
    else if (ev_wr_cmd) cmd_q <= reg_wdata;
  end
  assign cmd_o     = cmd_q;
  assign mem2mem_o = cmd_q[0];

  logic [NCH-1:0]    mask_q, swreq_q;
  mode_t             mode_q [NCH];
  logic [WORD_W-1:0] base_q [NCH];
  logic [WORD_W-1:0] cnt_q  [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_regs #(.CH_IDX(i), .SELW(SELW)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_wr_req   (ev_wr_req),
      .ev_wr_mask  (ev_wr_mask),
      .ev_wr_mode  (ev_wr_mode),
      .cmd_sel     (cmd_sel),
      .wdata       (reg_wdata),
      .ev_wide_wr  (ev_wide_wr),
      .wide_ch     (wide_ch),
      .wide_is_cnt (wide_is_cnt),
      .ptr_hi      (byte_ptr),
      .mask_q      (mask_q[i]),
      .swreq_q     (swreq_q[i]),
      .mode_q      (mode_q[i]),
      .base_q      (base_q[i]),
      .cnt_q       (cnt_q[i])
    );

    assign xfer_type_o[2*i +: 2]       = mode_q[i].xfer;
    assign svc_mode_o[2*i +: 2]        = mode_q[i].svc;
    assign auto_init_o[i]              = mode_q[i].autoinit;
    assign addr_dec_o[i]               = mode_q[i].dec;
    assign illegal_o[i]                = mode_illegal(mode_q[i], cmd_q[0]);
    assign base_addr_o[WORD_W*i +: WORD_W] = base_q[i];
    assign word_cnt_o[WORD_W*i +: WORD_W]  = cnt_q[i];
  end

  assign mask_o  = mask_q;
  assign swreq_o = swreq_q;

  dma_req_gate #(.NCH(NCH)) u_gate (
    .dreq  (dreq_hw),
    .swreq (swreq_q),
    .mask  (mask_q),
    .eff   (eff_req_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (ev_wide_rd)
      reg_rdata = pick_byte(wide_is_cnt ? cnt_q[wide_ch] : base_q[wide_ch], byte_ptr);
  end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] swreq,
  input logic [NCH-1:0] eff_req,
  input logic [NCH-1:0] illegal,
  input logic [2*NCH-1:0] xfer,
  input logic           byte_ptr,
  input logic           ev_wr_mask,
  input logic           ev_wr_req,
  input logic           ev_clr_ptr,
  input logic           ev_wide_acc
);
  logic [NCH-1:0] kind11;
  always_comb begin
    for (int i = 0; i < NCH; i++) kind11[i] = &xfer[2*i +: 2];
  end

  assert_mask_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_mask |=> $countones(mask ^ $past(mask)) <= 1);

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr_mask |=> $stable(mask));

  assert_req_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_req |=> $countones(swreq ^ $past(swreq)) <= 1);

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_req & mask) == '0);

  assert_clr_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr_ptr |=> !byte_ptr);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wide_acc |=> byte_ptr != $past(byte_ptr));

  assert_illegal_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal & ~kind11) == '0);
endmodule

bind dma_regif dma_regif_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mask        (mask_o),
  .swreq       (swreq_o),
  .eff_req     (eff_req_o),
  .illegal     (illegal_o),
  .xfer        (xfer_type_o),
  .byte_ptr    (byte_ptr),
  .ev_wr_mask  (ev_wr_mask),
  .ev_wr_req   (ev_wr_req),
  .ev_clr_ptr  (ev_clr_ptr),
  .ev_wide_acc (ev_wide_acc)
);

// File: tb/tb_dma_regif.sv
module tb_dma_regif;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {offset, data, expected mask, expected software requests}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'hA, 8'h00, 4'hE, 4'h0},
    {4'hA, 8'h02, 4'hA, 4'h0},
    {4'h9, 8'h05, 4'hA, 4'h2},
    {4'h9, 8'h04, 4'hA, 4'h3},
    {4'h9, 8'hF9, 4'hA, 4'h1},
    {4'hA, 8'h04, 4'hB, 4'h1},
    {4'hA, 8'h03, 4'h3, 4'h1},
    {4'h9, 8'h07, 4'h3, 4'h9},
    {4'hD, 8'hFF, 4'h3, 4'h9},
    {4'hF, 8'h00, 4'h3, 4'h9}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [3:0] dreq_hw = '0;
  logic [3:0] eff_req_o, mask_o, swreq_o, illegal_o, auto_init_o, addr_dec_o;
  logic [7:0] xfer_type_o, svc_mode_o, cmd_o;
  logic [63:0] base_addr_o, word_cnt_o;
  logic mem2mem_o;

  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regif dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .dreq_hw(dreq_hw),
    .eff_req_o(eff_req_o), .mask_o(mask_o), .swreq_o(swreq_o),
    .illegal_o(illegal_o), .auto_init_o(auto_init_o), .addr_dec_o(addr_dec_o),
    .xfer_type_o(xfer_type_o), .svc_mode_o(svc_mode_o),
    .base_addr_o(base_addr_o), .word_cnt_o(word_cnt_o),
    .cmd_o(cmd_o), .mem2mem_o(mem2mem_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    dreq_hw = 4'hF;
    #1;
    chk("R1 mask", mask_o, 4'hF);
    chk("R1 swreq", swreq_o, 4'h0);
    chk("R8 all masked", eff_req_o, 4'h0);
    chk("R1 cmd", cmd_o, 8'h00);
    chk("R1 base", base_addr_o, 64'h0);
    dreq_hw = 4'h0;

    // R2 R3 R10 vector walk
    for (int i = 0; i < NVEC; i++) begin
      do_wr(VEC[i][19:16], VEC[i][15:8]);
      chk("R3 mask after vector", mask_o, VEC[i][7:4]);
      chk("R2 swreq after vector", swreq_o, VEC[i][3:0]);
    end

    // R8 effective request: mask 0011, sw 1001
    dreq_hw = 4'b0110; #1;
    chk("R8 eff with dreq", eff_req_o, 4'b1100);
    dreq_hw = 4'b0000; #1;
    chk("R8 eff sw only", eff_req_o, 4'b1000);

    // R6 wide writes, flag clear since reset
    do_wr(4'h2, 8'h34); do_wr(4'h2, 8'h12);
    chk("R6 ch1 address", base_addr_o[31:16], 16'h1234);
    do_wr(4'h3, 8'hCD); do_wr(4'h3, 8'hAB);
    chk("R6 ch1 count", word_cnt_o[31:16], 16'hABCD);
    do_rd(4'h2, rv); chk("R6 read low", rv, 8'h34);
    do_rd(4'h3, rv); chk("R6 shared flag high", rv, 8'hAB);
    do_wr(4'hD, 8'hFF);
    do_wr(4'hC, 8'h5A);
    do_rd(4'h3, rv); chk("R5 cleared flag low", rv, 8'hCD);
    do_rd(4'h9, rv); chk("R10 read upper offset", rv, 8'h00);
    do_rd(4'h2, rv); chk("R10 no toggle on upper read", rv, 8'h12);
    do_wr(4'hC, 8'hFF);
    do_rd(4'h2, rv); chk("R5 any data clears", rv, 8'h34);
    do_wr(4'hC, 8'h00);
    do_wr(4'h6, 8'hEF); do_wr(4'h6, 8'hBE);
    chk("R6 ch3 address", base_addr_o[63:48], 16'hBEEF);
    chk("R6 ch1 address kept", base_addr_o[31:16], 16'h1234);

    // R4 mode write: ch1 block, decrement, auto-reload, read
    do_wr(4'hB, 8'hB9);
    chk("R4 ch1 kind", xfer_type_o[3:2], 2'b10);
    chk("R4 ch1 service", svc_mode_o[3:2], 2'b10);
    chk("R4 ch1 auto", auto_init_o[1], 1'b1);
    chk("R4 ch1 dec", addr_dec_o[1], 1'b1);
    chk("R9 ch1 legal", illegal_o[1], 1'b0);
    // ch2 single, illegal kind
    do_wr(4'hB, 8'h4E);
    chk("R4 ch2 service", svc_mode_o[5:4], 2'b01);
    chk("R4 ch2 kind stored", xfer_type_o[5:4], 2'b11);
    chk("R9 ch2 illegal", illegal_o, 4'b0100);
    chk("R4 ch1 kept", {svc_mode_o[3:2], xfer_type_o[3:2]}, 4'b1010);
    do_wr(4'h8, 8'h01);
    chk("R7 mem2mem", mem2mem_o, 1'b1);
    chk("R9 masked by mem2mem", illegal_o, 4'b0000);
    do_wr(4'h8, 8'hA0);
    chk("R7 cmd byte", cmd_o, 8'hA0);
    chk("R7 mem2mem off", mem2mem_o, 1'b0);
    chk("R9 illegal again", illegal_o, 4'b0100);
    do_wr(4'hB, 8'hCF);
    chk("R9 cascade no flag", illegal_o, 4'b0100);
    chk("R4 ch3 cascade", svc_mode_o[7:6], 2'b11);

    // R1 reset mid-run
    do_reset();
    chk("R1 mask after rerun", mask_o, 4'hF);
    chk("R1 swreq after rerun", swreq_o, 4'h0);
    chk("R1 mode cleared", svc_mode_o, 8'h00);
    do_wr(4'h0, 8'h11);
    chk("R1 flag clear after reset", base_addr_o[15:0], 16'h0011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule